// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

A synthesizable behavioural model of a 1 Kbit serial EEPROM that answers a host over three wires: chip select, shift clock and serial data in, plus a serial data out with its own output enable for tri-stating. A strap input chooses the organization: 64 words of 16 bits or 128 words of 8 bits. All three serial inputs are brought into the system clock domain, and every protocol event is taken from a rising shift-clock edge seen in that domain.

A command frame is a start bit, a two-bit opcode and an address, optionally followed by a data word. Reads return a dummy zero followed by the addressed word. Programming commands (word write, word erase, array erase, array write) are gated by a write-enable latch and run a self-timed cycle lasting a parameterized number of system clocks. A host that pulses chip select low and then high while the cycle runs sees ready/busy on the data output.

The command sequencer has the states ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_STATUS and ST_DONE. ST_IDLE goes to ST_OPC on a start bit (when not busy) or to ST_STATUS on a chip-select rise while busy; ST_OPC goes to ST_ADDR after two opcode bits; ST_ADDR goes to ST_READ (read), ST_DATA (write or array write with the latch set) or ST_DONE (all else); ST_DATA goes to ST_DONE after the last data bit; ST_READ goes to ST_DONE one edge after the last data bit. Every state returns to ST_IDLE when chip select is low.

Top module: `tw_eeprom`

## Requirements
- R1: A frame starts with a 1 sampled on a shift-clock rise while chip select is high; zeros before it are ignored. Two opcode bits follow, then the address MSB first.
- R2: With the strap high the array is 64 x 16 with a 6-bit address; with it low it is 128 x 8 with a 7-bit address, where byte address A is bits 7:0 of 16-bit word A>>1 when A[0]=0 and bits 15:8 when A[0]=1.
- R3: Opcode 10 reads: after the last address bit, the output is enabled and shows 0, then one data bit per shift-clock rise, MSB first; it changes only on shift-clock rises.
- R4: Opcode 00 with the top two address bits 11 sets the write-enable latch and 00 clears it; reset clears it. Programming commands have no effect while it is clear.
- R5: Reads return data whatever the latch state.
- R6: Opcode 01 writes the following data word to the address, overwriting with no prior erase.
- R7: Opcode 11 sets every bit of the addressed word to 1.
- R8: Opcode 00 with top address bits 10 sets the whole array to 1; with 01 it writes the following data word to every location.
- R9: A programming cycle lasts TWP_CYCLES system clocks; commands clocked in during it are ignored.
- R10: Chip select going high while the cycle runs enables the output showing 0, which turns to 1 when the cycle ends; a rise after the cycle has ended leaves the output disabled.
- R11: The output enable is low while chip select is low and whenever no read data or status is shown.
- R12: The cycle starts on the last data bit for writes and on the last address bit for erases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization strap: 1 = x16, 0 = x8 |
| do_o | output | 1 | Serial data out / ready-busy |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The assertions assume the serial inputs are slow against the system clock: every shift-clock phase and every chip-select pulse lasts longer than the three-cycle synchronize-and-detect path, and the strap stays fixed during a frame. The bench holds each shift-clock phase for six system clocks, keeps chip select low for four, changes data only while the shift clock is low, and moves the strap only between frames; it samples data out just before each shift-clock rise.

// File: rtl/tw_ee_pkg.sv
package tw_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_STATUS, ST_DONE
    } ee_state_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK = 2'b00;
    localparam logic [1:0] SUB_FILL = 2'b01;
    localparam logic [1:0] SUB_WIPE = 2'b10;
    localparam logic [1:0] SUB_OPEN = 2'b11;
endpackage

// File: rtl/tw_ee_sync.sv
module tw_ee_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] q_d_o
);
    logic [STAGES:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-1:0], d_i};
    end

    assign q_o   = stg_q[STAGES-1];
    assign q_d_o = stg_q[STAGES];
endmodule

// File: rtl/tw_ee_ptimer.sv
module tw_ee_ptimer #(
    parameter int TWP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(TWP_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start_i)    cnt_q <= CW'(TWP_CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);
endmodule

// File: rtl/tw_ee_array.sv
module tw_ee_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org_i,
    input  logic [ADDR_W:0]   raddr_i,
    output logic [WORD_W-1:0] rword_o,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W:0]   waddr_i,
    input  logic [WORD_W-1:0] wdata_i
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] widx, ridx;
    logic [WORD_W-1:0] rw;

    assign widx = org_i ? waddr_i[ADDR_W-1:0] : waddr_i[ADDR_W:1];
    assign ridx = org_i ? raddr_i[ADDR_W-1:0] : raddr_i[ADDR_W:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '1;
        end else if (we_i) begin
            for (int w = 0; w < DEPTH; w++) begin
                if (all_i || w == int'(widx)) begin
                    if (org_i)         mem_q[w] <= wdata_i;
                    else if (all_i)    mem_q[w] <= {wdata_i[HALF_W-1:0], wdata_i[HALF_W-1:0]};
                    else if (waddr_i[0]) mem_q[w][WORD_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
                    else               mem_q[w][HALF_W-1:0] <= wdata_i[HALF_W-1:0];
                end
            end
        end
    end

    assign rw = mem_q[ridx];
    assign rword_o = org_i ? rw
                   : {(raddr_i[0] ? rw[WORD_W-1:HALF_W] : rw[HALF_W-1:0]), {HALF_W{1'b0}}};
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_ee_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int TWP_CYCLES  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int BADDR_W = ADDR_W + 1;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    logic [2:0] sy_q, sy_d;
    logic cs_s, sk_s, di_s, cs_rise, sk_rise, unused_di_d;

    tw_ee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({di_i, sk_i, cs_i}), .q_o(sy_q), .q_d_o(sy_d));

    assign cs_s        = sy_q[0];
    assign sk_s        = sy_q[1];
    assign di_s        = sy_q[2];
    assign cs_rise     = cs_s & ~sy_d[0];
    assign sk_rise     = sk_s & ~sy_d[1];
    assign unused_di_d = sy_d[2];

    ee_state_t          state_q, nxt;
    logic [CNT_W-1:0]   cnt_q, aw_m1, dw_m1, dw;
    logic [1:0]         op_q, sub;
    logic [ADDR_W:0]    adr_q, adr_nx, pg_addr;
    logic [WORD_W-1:0]  dat_q, dat_nx, sh_q, rd_word, pg_data;
    logic               wen_q, do_q, busy;
    logic               pg_we, pg_all, wen_set, wen_clr, ld_rd;

    assign adr_nx = {adr_q[ADDR_W-1:0], di_s};
    assign dat_nx = {dat_q[WORD_W-2:0], di_s};
    assign aw_m1  = org_i ? CNT_W'(ADDR_W - 1) : CNT_W'(BADDR_W - 1);
    assign dw     = org_i ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
    assign dw_m1  = dw - 1'b1;
    assign sub    = org_i ? adr_nx[ADDR_W-1 -: 2] : adr_nx[BADDR_W-1 -: 2];

    tw_ee_ptimer #(.TWP_CYCLES(TWP_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(pg_we), .busy_o(busy));

    tw_ee_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .org_i(org_i), .raddr_i(adr_nx), .rword_o(rd_word),
        .we_i(pg_we), .all_i(pg_all), .waddr_i(pg_addr), .wdata_i(pg_data));

    // next state and command decode
    always_comb begin
        nxt = state_q; pg_we = 1'b0; pg_all = 1'b0; pg_addr = adr_q; pg_data = dat_nx;
        wen_set = 1'b0; wen_clr = 1'b0; ld_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_rise && busy)                     nxt = ST_STATUS;
                else if (sk_rise && di_s && !busy)       nxt = ST_OPC;
            end
            ST_OPC:  if (sk_rise && cnt_q == CNT_W'(1)) nxt = ST_ADDR;
            ST_ADDR: if (sk_rise && cnt_q == aw_m1) begin
                nxt = ST_DONE;
                pg_addr = adr_nx;
                unique case (op_q)
                    OP_READ:  begin nxt = ST_READ; ld_rd = 1'b1; end
                    OP_WRITE: if (wen_q) nxt = ST_DATA;
                    OP_ERASE: begin pg_we = wen_q; pg_data = '1; end
                    OP_EXT: begin
                        unique case (sub)
                            SUB_OPEN: wen_set = 1'b1;
                            SUB_LOCK: wen_clr = 1'b1;
                            SUB_WIPE: begin pg_we = wen_q; pg_all = 1'b1; pg_data = '1; end
                            SUB_FILL: if (wen_q) nxt = ST_DATA;
                        endcase
                    end
                endcase
            end
            ST_DATA: if (sk_rise && cnt_q == dw_m1) begin
                nxt = ST_DONE; pg_we = 1'b1; pg_all = (op_q == OP_EXT);
            end
            ST_READ: if (sk_rise && cnt_q == dw) nxt = ST_DONE;
            ST_STATUS, ST_DONE: begin end
        endcase
        if (!cs_s) begin
            nxt = ST_IDLE; pg_we = 1'b0; wen_set = 1'b0; wen_clr = 1'b0; ld_rd = 1'b0;
        end
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; adr_q <= '0;
            dat_q <= '0; sh_q <= '0; wen_q <= 1'b0; do_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (nxt != state_q) cnt_q <= '0;
            else if (sk_rise)   cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_OPC  && sk_rise) op_q  <= {op_q[0], di_s};
            if (state_q == ST_ADDR && sk_rise) adr_q <= adr_nx;
            if (state_q == ST_DATA && sk_rise) dat_q <= dat_nx;
            if (wen_set)      wen_q <= 1'b1;
            else if (wen_clr) wen_q <= 1'b0;
            if (ld_rd) begin
                sh_q <= rd_word; do_q <= 1'b0;
            end else if (state_q == ST_READ && sk_rise && cnt_q != dw) begin
                do_q <= sh_q[WORD_W-1];
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        do_oe_o = (state_q == ST_READ) || (state_q == ST_STATUS);
        do_o    = (state_q == ST_STATUS) ? !busy : do_q;
    end

    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe_o);
    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && cs_s && !sk_rise) |=> $stable(do_q));
    // R4
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> wen_q);
    // R10
    status_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_s && cs_rise && busy) |=> do_oe_o && !do_o);
endmodule

// File: tb/tw_eeprom_tb_top.sv
`timescale 1ns/1ps
module tw_eeprom_tb_top;
    localparam int H   = 6;
    localparam int TWP = 600;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    tw_eeprom #(.TWP_CYCLES(TWP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
        .do_o(do_o), .do_oe_o(do_oe));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int aw(); return org ? 6 : 7; endfunction
    function automatic int dwid(); return org ? 16 : 8; endfunction

    task automatic cs_hi();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk) begin cs = 1'b0; sk = 1'b0; end
        repeat (4) @(posedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk) di = b;
        repeat (H) @(posedge clk);
        @(negedge clk) sk = 1'b1;
        repeat (H) @(posedge clk);
        @(negedge clk) sk = 1'b0;
    endtask

    task automatic send(input logic [1:0] op, input logic [6:0] adr, input logic [15:0] d, input bit with_d);
        bit_out(1'b1); bit_out(op[1]); bit_out(op[0]);
        for (int i = aw() - 1; i >= 0; i--) bit_out(adr[i]);
        if (with_d) for (int i = dwid() - 1; i >= 0; i--) bit_out(d[i]);
    endtask

    task automatic prog(input logic [1:0] op, input logic [6:0] adr, input logic [15:0] d, input bit with_d);
        cs_hi(); send(op, adr, d, with_d); cs_lo();
        repeat (TWP + 20) @(posedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [6:0] adr);
        cs_hi(); send(op, adr, 16'h0, 1'b0); cs_lo();
    endtask

    task automatic rd_chk(input logic [6:0] adr, input logic [15:0] exp, input string req, input int lead);
        logic [15:0] got = '0;
        cs_hi();
        for (int i = 0; i < lead; i++) bit_out(1'b0);
        send(2'b10, adr, 16'h0, 1'b0);
        for (int i = 0; i <= dwid(); i++) begin
            repeat (H) @(posedge clk);
            @(negedge clk);
            if (i == 0) begin
                chk({req, " R3 dummy"}, {15'h0, do_o}, 16'h0);
                chk({req, " R3 oe"}, {15'h0, do_oe}, 16'h1);
            end else got = {got[14:0], do_o};
            sk = 1'b1;
            repeat (H) @(posedge clk);
            @(negedge clk) sk = 1'b0;
        end
        chk(req, got, exp);
        cs_lo();
        @(negedge clk) chk("R11 oe with cs low", {15'h0, do_oe}, 16'h0);
    endtask

    // R10 R9 R12: status during a write, ignored command while busy
    task automatic t_status();
        cs_hi(); send(2'b01, 7'd9, 16'h6C39, 1'b1); cs_lo(); cs_hi();
        @(negedge clk);
        chk("R10 busy oe", {15'h0, do_oe}, 16'h1);
        chk("R12 busy after last data bit", {15'h0, do_o}, 16'h0);
        send(2'b01, 7'd9, 16'h0000, 1'b1);
        repeat (TWP - 360) @(posedge clk);
        @(negedge clk) chk("R9 still busy", {15'h0, do_o}, 16'h0);
        repeat (60) @(posedge clk);
        @(negedge clk) begin
            chk("R10 ready", {15'h0, do_o}, 16'h1);
            chk("R10 ready oe", {15'h0, do_oe}, 16'h1);
        end
        cs_lo(); cs_hi();
        @(negedge clk) chk("R10 no status after end", {15'h0, do_oe}, 16'h0);
        cs_lo();
        rd_chk(7'd9, 16'h6C39, "R9 busy command ignored", 0);
    endtask

    task automatic t_x8();
        org = 1'b0;
        rd_chk(7'd10, 16'h00EF, "R2 x8 low byte", 0);
        rd_chk(7'd11, 16'h00BE, "R2 x8 high byte", 0);
        prog(2'b01, 7'd12, 16'h005A, 1'b1);
        org = 1'b1;
        rd_chk(7'd6, 16'hFF5A, "R2 x8 write into word", 0);
    endtask

    task automatic t_erase();
        cs_hi(); send(2'b11, 7'd5, 16'h0, 1'b0); cs_lo(); cs_hi();
        @(negedge clk) begin
            chk("R12 erase busy", {15'h0, do_o}, 16'h0);
            chk("R12 erase oe", {15'h0, do_oe}, 16'h1);
        end
        cs_lo();
        repeat (TWP + 20) @(posedge clk);
        rd_chk(7'd5, 16'hFFFF, "R7 erase word", 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) chk("R11 oe at reset", {15'h0, do_oe}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        prog(2'b01, 7'd5, 16'hA55A, 1'b1);
        rd_chk(7'd5, 16'hFFFF, "R4 write blocked R5 read", 0);
        cmd(2'b00, 7'b0110000);
        prog(2'b01, 7'd5, 16'h1234, 1'b1);
        rd_chk(7'd5, 16'h1234, "R1 leading zeros R6 write", 2);
        prog(2'b01, 7'd5, 16'hBEEF, 1'b1);
        rd_chk(7'd5, 16'hBEEF, "R6 overwrite", 0);
        t_status();
        t_x8();
        t_erase();
        prog(2'b00, 7'b0010000, 16'hC3A5, 1'b1);
        rd_chk(7'd0, 16'hC3A5, "R8 fill first", 0);
        rd_chk(7'd63, 16'hC3A5, "R8 fill last", 0);
        prog(2'b00, 7'b0100000, 16'h0, 1'b0);
        rd_chk(7'd17, 16'hFFFF, "R8 wipe", 0);
        cmd(2'b00, 7'b0000000);
        prog(2'b01, 7'd2, 16'h0000, 1'b1);
        rd_chk(7'd2, 16'hFFFF, "R4 locked again R5", 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule